// File: doc/BRIEF.md
# Ring-Gated Call Controller

This block carries out the hardware side of a privilege-changing call into a code segment that exports numbered entry gates, and the return that undoes it. Each segment has a small descriptor: how many gates it exports, the ring its code runs in (the execution ring) and the least privileged ring still allowed to call it (the call bracket). Ring numbers are unsigned, and a smaller number means more privilege. A gate table holds the entry address of every gate word of every segment. Gate words are numbered from 1, so offset 0 never names a gate.

A call request names a segment, a gate offset, the caller's ring and the address to come back to. The request is admitted only if the gate exists and the caller's ring is strictly above the execution ring and no higher than the call bracket. The return stack must also have room. An admitted call saves the return address and caller ring on a bounded return stack. One cycle later it reports the gate's entry address and the new ring. A return request pops the stack and reports the saved address and ring. A return is refused if the stack is empty or if it would move to a more privileged ring than the one it is issued from. A refused request raises a fault with a reason code and changes no state.

Descriptors and gate words are loaded through two plain write ports before use.

Top module: `ring_gate_ctl`

## Requirements
- R1: After reset `done_o`, `fault_o`, `fault_code_o`, `pc_o` and `ring_o` are all 0. Every segment's gate count is 0, so any call before configuration faults with code 1.
- R2: A call whose gate offset is 0 or greater than the segment's gate count faults with code 1 (bad gate). This check takes priority over all others.
- R3: A call with a valid gate is admitted only if execution ring < `cur_ring` <= call bracket. Otherwise it faults with code 2 (ring out of bracket). With the bracket one above the execution ring, only that one ring may call. With the bracket equal to the execution ring, no ring may call.
- R4: An admitted call raises `done_o` for exactly one cycle, on the clock edge after the request. In that cycle `pc_o` is the gate-table word (segment, offset) and `ring_o` is the segment's execution ring.
- R5: An admitted call pushes {`ret_addr`, `cur_ring`}. An admitted return pops the newest entry and, one cycle later, pulses `done_o` with `pc_o` set to the saved address and `ring_o` set to the saved ring. The stack order is last-in first-out.
- R6: A call that passes R2 and R3 while the stack holds DEPTH entries faults with code 3 (stack full) and pushes nothing.
- R7: A return with an empty stack faults with code 4 (stack empty).
- R8: A return whose saved ring is lower than `cur_ring` faults with code 5 (return to higher privilege) and leaves the entry on the stack. A saved ring equal to `cur_ring` is admitted.
- R9: A refused request pulses `fault_o` one cycle after the request, with `done_o` low. `pc_o`, `ring_o` and the stack keep their values. `fault_code_o` is 0 whenever `fault_o` is low.
- R10: When `call_req` and `ret_req` are high together, only the call is served and the return request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write a segment descriptor |
| cfg_seg | input | SEG_W | Descriptor index |
| cfg_ngates | input | GATE_W | Number of gates exported |
| cfg_xring | input | RING_W | Execution ring of the segment |
| cfg_cbrk | input | RING_W | Call bracket (highest caller ring) |
| gt_we | input | 1 | Write a gate-table word |
| gt_seg | input | SEG_W | Gate-table segment |
| gt_word | input | GATE_W | Gate word number, 1..GATE_MAX |
| gt_data | input | ADDR_W | Entry address for that gate |
| call_req | input | 1 | Call request |
| call_seg | input | SEG_W | Target segment |
| call_gate | input | GATE_W | Target gate offset |
| ret_addr | input | ADDR_W | Address to resume at on return |
| ret_req | input | 1 | Return request |
| cur_ring | input | RING_W | Ring of the requesting code |
| done_o | output | 1 | Request admitted (one-cycle pulse) |
| fault_o | output | 1 | Request refused (one-cycle pulse) |
| fault_code_o | output | 3 | Refusal reason, 0 when none |
| pc_o | output | ADDR_W | Next program address |
| ring_o | output | RING_W | Next ring |

## Verification
The in-module assertions watch four things on every cycle: stack overflow and underflow, the exclusion of done and fault, and that a fault leaves the outputs untouched. They also check that an admitted call always lowers the ring and that an admitted return never raises privilege. Fault-code priority, the exact bracket edges, the entry address fetched for each gate, and the last-in first-out order of nested returns can only be shown by the bench's scenarios. To cover these, the bench sweeps every segment, gate offset and caller ring of a four-segment configuration. It also drives the full, empty and simultaneous-request cases.

// File: rtl/ring_gate_pkg.sv
package ring_gate_pkg;
   typedef enum logic [2:0] {
      RG_NONE      = 3'd0,
      RG_BAD_GATE  = 3'd1,
      RG_BAD_RING  = 3'd2,
      RG_STK_FULL  = 3'd3,
      RG_STK_EMPTY = 3'd4,
      RG_RET_RING  = 3'd5
   } rg_fault_e;
endpackage

// File: rtl/rg_seg_regs.sv
// Per-segment descriptor file: gate count, execution ring, call bracket.
module rg_seg_regs #(
   parameter int SEG_CNT = 4,
   parameter int SEG_W   = 2,
   parameter int GATE_W  = 3,
   parameter int RING_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEG_W-1:0]  cfg_seg,
   input  logic [GATE_W-1:0] cfg_ngates,
   input  logic [RING_W-1:0] cfg_xring,
   input  logic [RING_W-1:0] cfg_cbrk,
   input  logic [SEG_W-1:0]  rd_seg,
   output logic [GATE_W-1:0] rd_ngates,
   output logic [RING_W-1:0] rd_xring,
   output logic [RING_W-1:0] rd_cbrk
);
   logic [SEG_CNT-1:0][GATE_W-1:0] ng_v;
   logic [SEG_CNT-1:0][RING_W-1:0] xr_v;
   logic [SEG_CNT-1:0][RING_W-1:0] cb_v;

   for (genvar s = 0; s < SEG_CNT; s++) begin : g_seg
      logic [GATE_W-1:0] ng_r;
      logic [RING_W-1:0] xr_r;
      logic [RING_W-1:0] cb_r;
      logic              hit;
      assign hit = cfg_we && (cfg_seg == SEG_W'(s));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ng_r <= '0;
            xr_r <= '0;
            cb_r <= '0;
         end else if (hit) begin
            ng_r <= cfg_ngates;
            xr_r <= cfg_xring;
            cb_r <= cfg_cbrk;
         end
      end
      assign ng_v[s] = ng_r;
      assign xr_v[s] = xr_r;
      assign cb_v[s] = cb_r;
   end

   always_comb begin
      rd_ngates = '0;
      rd_xring  = '0;
      rd_cbrk   = '0;
      for (int s = 0; s < SEG_CNT; s++) begin
         if (rd_seg == SEG_W'(s)) begin
            rd_ngates = ng_v[s];
            rd_xring  = xr_v[s];
            rd_cbrk   = cb_v[s];
         end
      end
   end
endmodule

// File: rtl/rg_gate_ram.sv
// Gate entry table: synchronous-read RAM, gate words numbered from 1.
module rg_gate_ram #(
   parameter int SEG_CNT  = 4,
   parameter int SEG_W    = 2,
   parameter int GATE_MAX = 4,
   parameter int GATE_W   = 3,
   parameter int ADDR_W   = 16
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [SEG_W-1:0]  wr_seg,
   input  logic [GATE_W-1:0] wr_word,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [SEG_W-1:0]  rd_seg,
   input  logic [GATE_W-1:0] rd_word,
   output logic [ADDR_W-1:0] rd_data
);
   localparam int WORDS = SEG_CNT * GATE_MAX;
   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

   logic [ADDR_W-1:0] mem [WORDS];

   function automatic logic [IDX_W-1:0] idx_of(input logic [SEG_W-1:0] s,
                                                input logic [GATE_W-1:0] w);
      int unsigned t;
      t = int'(s) * GATE_MAX + int'(w) - 1;
      return IDX_W'(t);
   endfunction

   logic wr_ok;
   assign wr_ok = wr_en && (wr_word != '0) && (int'(wr_word) <= GATE_MAX)
                  && (int'(wr_seg) < SEG_CNT);

   always_ff @(posedge clk) begin
      if (wr_ok) mem[idx_of(wr_seg, wr_word)] <= wr_data;
      if (rd_en) rd_data <= mem[idx_of(rd_seg, rd_word)];
   end
endmodule

// File: rtl/rg_ret_stack.sv
// Bounded last-in first-out stack of {return address, ring}.
module rg_ret_stack #(
   parameter int DEPTH = 4,
   parameter int ENT_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [ENT_W-1:0] push_data,
   output logic [ENT_W-1:0] top_data,
   output logic             full,
   output logic             empty
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int PTR_W = $clog2(DEPTH);

   logic [ENT_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0] cnt;

   assign full     = (cnt == CNT_W'(DEPTH));
   assign empty    = (cnt == '0);
   assign top_data = mem[PTR_W'(cnt - CNT_W'(1))];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (push && !full) begin
         mem[PTR_W'(cnt)] <= push_data;
         cnt <= cnt + CNT_W'(1);
      end else if (pop && !empty) begin
         cnt <= cnt - CNT_W'(1);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full));  // R6
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && empty));  // R7
   AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop));  // R10
endmodule

// File: rtl/rg_call_check.sv
// Admission decision for a call or a return, with fault priority.
module rg_call_check
   import ring_gate_pkg::*;
#(
   parameter int GATE_W = 3,
   parameter int RING_W = 3
) (
   input  logic              call_req,
   input  logic              ret_req,
   input  logic [GATE_W-1:0] gate,
   input  logic [GATE_W-1:0] ngates,
   input  logic [RING_W-1:0] xring,
   input  logic [RING_W-1:0] cbrk,
   input  logic [RING_W-1:0] cur_ring,
   input  logic              stk_full,
   input  logic              stk_empty,
   input  logic [RING_W-1:0] saved_ring,
   output logic              call_ok,
   output logic              ret_ok,
   output rg_fault_e         code
);
   logic gate_bad, ring_bad;
   assign gate_bad = (gate == '0) || (gate > ngates);
   assign ring_bad = !((xring < cur_ring) && (cur_ring <= cbrk));

   always_comb begin
      call_ok = 1'b0;
      ret_ok  = 1'b0;
      code    = RG_NONE;
      if (call_req) begin
         if (gate_bad)      code = RG_BAD_GATE;
         else if (ring_bad) code = RG_BAD_RING;
         else if (stk_full) code = RG_STK_FULL;
         else               call_ok = 1'b1;
      end else if (ret_req) begin
         if (stk_empty)                  code = RG_STK_EMPTY;
         else if (saved_ring < cur_ring) code = RG_RET_RING;
         else                            ret_ok = 1'b1;
      end
   end
endmodule

// File: rtl/ring_gate_ctl.sv
module ring_gate_ctl
   import ring_gate_pkg::*;
#(
   parameter int SEG_CNT  = 4,
   parameter int GATE_MAX = 4,
   parameter int RING_W   = 3,
   parameter int ADDR_W   = 16,
   parameter int DEPTH    = 4,
   parameter int SEG_W    = $clog2(SEG_CNT),
   parameter int GATE_W   = $clog2(GATE_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEG_W-1:0]  cfg_seg,
   input  logic [GATE_W-1:0] cfg_ngates,
   input  logic [RING_W-1:0] cfg_xring,
   input  logic [RING_W-1:0] cfg_cbrk,
   input  logic              gt_we,
   input  logic [SEG_W-1:0]  gt_seg,
   input  logic [GATE_W-1:0] gt_word,
   input  logic [ADDR_W-1:0] gt_data,
   input  logic              call_req,
   input  logic [SEG_W-1:0]  call_seg,
   input  logic [GATE_W-1:0] call_gate,
   input  logic [ADDR_W-1:0] ret_addr,
   input  logic              ret_req,
   input  logic [RING_W-1:0] cur_ring,
   output logic              done_o,
   output logic              fault_o,
   output logic [2:0]        fault_code_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [RING_W-1:0] ring_o
);
   localparam int ENT_W = ADDR_W + RING_W;

   if (SEG_CNT < 2) begin : g_bad_seg
      $error("SEG_CNT must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (GATE_MAX < 1) begin : g_bad_gate
      $error("GATE_MAX must be at least 1");
   end
   if (RING_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("RING_W and ADDR_W must be positive");
   end

   logic [GATE_W-1:0] d_ngates;
   logic [RING_W-1:0] d_xring, d_cbrk;

   rg_seg_regs #(.SEG_CNT(SEG_CNT), .SEG_W(SEG_W), .GATE_W(GATE_W), .RING_W(RING_W)) u_desc (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_seg(cfg_seg),
      .cfg_ngates(cfg_ngates), .cfg_xring(cfg_xring), .cfg_cbrk(cfg_cbrk),
      .rd_seg(call_seg), .rd_ngates(d_ngates), .rd_xring(d_xring), .rd_cbrk(d_cbrk));

   logic             stk_full, stk_empty;
   logic [ENT_W-1:0] stk_top;
   logic             call_ok, ret_ok;
   rg_fault_e        chk_code;

   rg_call_check #(.GATE_W(GATE_W), .RING_W(RING_W)) u_chk (
      .call_req(call_req), .ret_req(ret_req), .gate(call_gate),
      .ngates(d_ngates), .xring(d_xring), .cbrk(d_cbrk), .cur_ring(cur_ring),
      .stk_full(stk_full), .stk_empty(stk_empty),
      .saved_ring(stk_top[RING_W-1:0]),
      .call_ok(call_ok), .ret_ok(ret_ok), .code(chk_code));

   rg_ret_stack #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_stk (
      .clk(clk), .rst_n(rst_n), .push(call_ok), .pop(ret_ok),
      .push_data({ret_addr, cur_ring}), .top_data(stk_top),
      .full(stk_full), .empty(stk_empty));

   logic [ADDR_W-1:0] gate_pc;

   rg_gate_ram #(.SEG_CNT(SEG_CNT), .SEG_W(SEG_W), .GATE_MAX(GATE_MAX),
                 .GATE_W(GATE_W), .ADDR_W(ADDR_W)) u_gates (
      .clk(clk), .wr_en(gt_we), .wr_seg(gt_seg), .wr_word(gt_word), .wr_data(gt_data),
      .rd_en(call_ok), .rd_seg(call_seg), .rd_word(call_gate), .rd_data(gate_pc));

   logic              done_q, fault_q, from_call_q;
   logic [2:0]        code_q;
   logic [ADDR_W-1:0] ret_pc_q;
   logic [RING_W-1:0] ring_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q      <= 1'b0;
         fault_q     <= 1'b0;
         code_q      <= 3'd0;
         from_call_q <= 1'b0;
         ret_pc_q    <= '0;
         ring_q      <= '0;
      end else begin
         done_q  <= call_ok || ret_ok;
         fault_q <= (chk_code != RG_NONE);
         code_q  <= chk_code;
         if (call_ok) begin
            from_call_q <= 1'b1;
            ring_q      <= d_xring;
         end else if (ret_ok) begin
            from_call_q <= 1'b0;
            ret_pc_q    <= stk_top[ENT_W-1:RING_W];
            ring_q      <= stk_top[RING_W-1:0];
         end
      end
   end

   assign done_o       = done_q;
   assign fault_o      = fault_q;
   assign fault_code_o = code_q;
   assign pc_o         = from_call_q ? gate_pc : ret_pc_q;
   assign ring_o       = ring_q;

   AST_ZERO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      call_req && (call_gate == '0) |=> fault_o && (fault_code_o == 3'd1));  // R2
   AST_CALL_LOWERS_RING: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && $past(call_req) |-> ring_o < $past(cur_ring));  // R3
   AST_RET_NOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && $past(ret_req && !call_req) |-> ring_o >= $past(cur_ring));  // R8
   AST_DONE_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && fault_o));  // R9
   AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (ring_o == $past(ring_o)) && (pc_o == $past(pc_o)));  // R9
   AST_QUIET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_o |-> fault_code_o == 3'd0);  // R9
   AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !call_req && !ret_req |=> !done_o && !fault_o);  // R4
endmodule

// File: tb/ring_gate_ctl_tb_top.sv
module ring_gate_ctl_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 0;
   logic [1:0]  cfg_seg = 0;
   logic [2:0]  cfg_ngates = 0, cfg_xring = 0, cfg_cbrk = 0;
   logic        gt_we = 0;
   logic [1:0]  gt_seg = 0;
   logic [2:0]  gt_word = 0;
   logic [15:0] gt_data = 0;
   logic        call_req = 0, ret_req = 0;
   logic [1:0]  call_seg = 0;
   logic [2:0]  call_gate = 0, cur_ring = 0;
   logic [15:0] ret_addr = 0;
   logic        done_o, fault_o;
   logic [2:0]  fault_code_o, ring_o;
   logic [15:0] pc_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   ring_gate_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_seg(cfg_seg),
      .cfg_ngates(cfg_ngates), .cfg_xring(cfg_xring), .cfg_cbrk(cfg_cbrk),
      .gt_we(gt_we), .gt_seg(gt_seg), .gt_word(gt_word), .gt_data(gt_data),
      .call_req(call_req), .call_seg(call_seg), .call_gate(call_gate),
      .ret_addr(ret_addr), .ret_req(ret_req), .cur_ring(cur_ring),
      .done_o(done_o), .fault_o(fault_o), .fault_code_o(fault_code_o),
      .pc_o(pc_o), .ring_o(ring_o));

   int errors = 0, checks = 0;
   bit finished = 0;
   logic [15:0] exp_pc = 0;
   logic [2:0]  exp_ring = 0;

   int seg_ng[4] = '{2, 4, 0, 3};
   int seg_xb[4] = '{0, 1, 2, 3};
   int seg_cb[4] = '{1, 4, 7, 3};

   function automatic logic [15:0] entry_of(int s, int w);
      return 16'(16'h4000 + s * 256 + w * 4);
   endfunction

   task automatic check(input string tag, input logic e_done, input logic e_fault,
                        input logic [2:0] e_code, input logic [15:0] e_pc,
                        input logic [2:0] e_ring);
      checks++;
      if (done_o !== e_done || fault_o !== e_fault || fault_code_o !== e_code ||
          pc_o !== e_pc || ring_o !== e_ring) begin
         errors++;
         $display("FAIL %s: got done=%0b fault=%0b code=%0d pc=%h ring=%0d, expected done=%0b fault=%0b code=%0d pc=%h ring=%0d",
                  tag, done_o, fault_o, fault_code_o, pc_o, ring_o,
                  e_done, e_fault, e_code, e_pc, e_ring);
      end
   endtask

   task automatic expect_done(input string tag, input logic [15:0] pc, input logic [2:0] ring);
      exp_pc = pc;
      exp_ring = ring;
      check(tag, 1'b1, 1'b0, 3'd0, pc, ring);
   endtask

   task automatic expect_fault(input string tag, input logic [2:0] code);
      check(tag, 1'b0, 1'b1, code, exp_pc, exp_ring);
   endtask

   task automatic do_req(input logic c, input logic r, input int s, input int g,
                         input int ring, input logic [15:0] ra);
      @(negedge clk);
      call_req = c; ret_req = r;
      call_seg = 2'(s); call_gate = 3'(g); cur_ring = 3'(ring); ret_addr = ra;
      @(negedge clk);
      call_req = 0; ret_req = 0;
   endtask

   task automatic do_call(input int s, input int g, input int ring, input logic [15:0] ra);
      do_req(1'b1, 1'b0, s, g, ring, ra);
   endtask

   task automatic do_ret(input int ring);
      do_req(1'b0, 1'b1, 0, 0, ring, 16'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset outputs
      check("R1 reset", 1'b0, 1'b0, 3'd0, 16'h0, 3'd0);
      // R1: unconfigured segment has zero gates
      do_call(1, 1, 2, 16'h1234);
      expect_fault("R1 unconfigured", 3'd1);

      // configuration
      for (int s = 0; s < 4; s++) begin
         @(negedge clk);
         cfg_we = 1; cfg_seg = 2'(s);
         cfg_ngates = 3'(seg_ng[s]); cfg_xring = 3'(seg_xb[s]); cfg_cbrk = 3'(seg_cb[s]);
         for (int w = 1; w <= 4; w++) begin
            @(negedge clk);
            cfg_we = 0;
            gt_we = 1; gt_seg = 2'(s); gt_word = 3'(w); gt_data = entry_of(s, w);
         end
         @(negedge clk);
         gt_we = 0;
      end

      // sweep: every segment, offset 0..7, caller ring 0..7
      for (int s = 0; s < 4; s++) begin
         for (int g = 0; g < 8; g++) begin
            for (int r = 0; r < 8; r++) begin
               logic [15:0] ra;
               ra = 16'(16'h8000 + s * 64 + g * 8 + r);
               do_call(s, g, r, ra);
               if (g == 0 || g > seg_ng[s]) begin
                  expect_fault("R2 R9 bad gate", 3'd1);
               end else if (!(seg_xb[s] < r && r <= seg_cb[s])) begin
                  expect_fault("R3 R9 ring bracket", 3'd2);
               end else begin
                  expect_done("R4 legal call", entry_of(s, g), 3'(seg_xb[s]));
                  do_ret(seg_xb[s]);
                  expect_done("R5 return", ra, 3'(r));
               end
            end
         end
      end

      // R6: fill the stack, then one more call
      for (int k = 0; k < 4; k++) begin
         do_call(1, k + 1, 2 + (k % 3), 16'(16'hA000 + k));
         expect_done("R6 fill", entry_of(1, k + 1), 3'd1);
      end
      do_call(1, 1, 3, 16'hAFFF);
      expect_fault("R6 stack full", 3'd3);
      // R5: last-in first-out unwinding
      for (int k = 3; k >= 0; k--) begin
         do_ret(1);
         expect_done("R5 lifo", 16'(16'hA000 + k), 3'(2 + (k % 3)));
      end
      // R7: return on empty stack
      do_ret(1);
      expect_fault("R7 stack empty", 3'd4);

      // R8: return to a more privileged ring is refused, entry kept
      do_call(1, 2, 2, 16'hB002);
      expect_done("R8 setup", entry_of(1, 2), 3'd1);
      do_ret(3);
      expect_fault("R8 ret ring", 3'd5);
      do_ret(2);
      expect_done("R8 equal ring kept entry", 16'hB002, 3'd2);

      // R10: call and return together, only the call is served
      do_req(1'b1, 1'b1, 0, 1, 1, 16'hC001);
      expect_done("R10 both", entry_of(0, 1), 3'd0);
      do_ret(0);
      expect_done("R10 one entry", 16'hC001, 3'd1);
      do_ret(0);
      expect_fault("R10 R7 nothing left", 3'd4);

      // R9: idle cycle after a fault shows no pulse and held outputs
      @(negedge clk);
      check("R9 idle", 1'b0, 1'b0, 3'd0, exp_pc, exp_ring);

      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule